// File: doc/BRIEF.md
# Daisy-Chain Serial Loader with Idle-Timeout Latch

This block takes in a long configuration word over a two-wire serial link: a data line and a shift clock. It runs on a free-running local oscillator clock. Both serial inputs pass through a two-flop synchronizer. Each detected rising edge of the shift clock moves one bit into a 224-bit shift register. The most significant bit of that register drives a serial data output. A re-timed single-cycle clock pulse is also produced for each edge. Together these two outputs let identical blocks be chained in series.

There is no load or select pin. The block measures the oscillator-cycle spacing of the two most recent shift-clock edges. When the shift clock then stays idle for eight times that spacing, it issues a one-cycle latch pulse. The idle limit is never below 8 or above 16384 cycles. On the latch pulse, the shift register is copied to a parallel holding register, but only if the six top bits carry the write code. Other blocks decode the holding register into its fields.

Top module: `serial_chain_latch`

## Requirements
- R1: Each shift-clock rising edge seen after synchronization shifts the data bit into bit 0, and every stored bit moves one place toward bit 223. A word sent bit 223 first therefore ends up in the register in its original order.
- R2: `sdoOut` always equals bit 223 of the shift register. It changes only in the cycle after a detected shift-clock edge, so it repeats the bit that entered 224 edges earlier.
- R3: For every detected shift-clock edge, `sckOut` is high for exactly one oscillator cycle. That cycle falls one cycle after `sdoOut` has taken its new value.
- R4: The idle limit is 8 × P oscillator cycles, where P is the spacing of the last two detected edges, clamped to the range 8 to 16384. Once the time since the last edge reaches the limit, `latchPulse` goes high.
- R5: A gap in the shift clock shorter than the idle limit produces no latch pulse.
- R6: `latchPulse` lasts one cycle and fires at most once per idle period. A new shift-clock edge is needed before another pulse can fire.
- R7: On a latch pulse, `holdWord` is loaded from the shift register only when bits 223:218 equal 6'b100101. Otherwise `holdWord` keeps its value, although the pulse still appears.
- R8: When no earlier edge exists since reset, the spacing counts as zero, so the idle limit is the minimum of 8 cycles.
- R9: Synchronous reset clears the shift register, `holdWord`, the interval counters, `sckOut` and `latchPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| sckIn | input | 1 | External shift clock, asynchronous |
| sdiIn | input | 1 | External serial data, asynchronous |
| sdoOut | output | 1 | Serial data toward the next block in the chain |
| sckOut | output | 1 | Re-timed single-cycle shift clock toward the next block |
| latchPulse | output | 1 | One-cycle pulse marking an inferred end of word |
| holdWord | output | 224 | Parallel holding register |

## Verification
Some properties are checked on every cycle:
- The latch pulse and the forwarded clock are single-cycle.
- The latch pulse never overlaps forwarded-clock activity.
- The holding register moves only on a latch that carries the write code.
- The serial output moves only after a detected edge.

The adaptive timeout itself can only be shown by the bench scenarios:
- a short mid-word pause that must not latch;
- a long pause that must latch exactly once;
- a lone edge after reset, where the 8-cycle minimum applies;
- a very slow shift clock, which must latch after the 16384-cycle ceiling but not before it.

// File: rtl/chain_pkg.sv
package chain_pkg;

  // Strobes from control to datapath, one set per oscillator cycle.
  typedef struct packed {
    logic shiftEn;   // a synchronized shift-clock edge was seen
    logic dataBit;   // synchronized serial bit to shift in
    logic latchEn;   // idle limit reached: copy the word if the code matches
  } chainStrobe_t;

endpackage

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_SHIFT   = 3,
  parameter int TMO_MIN     = 8,
  parameter int TMO_MAX     = 16384
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sckIn,
  input  logic         sdiIn,
  output chainStrobe_t strobe,
  output logic         sckOut,
  output logic         latchPulse
);

  localparam int CNT_W  = $clog2(TMO_MAX + 1);
  localparam int WIDE_W = CNT_W + TMO_SHIFT;
  localparam logic [CNT_W-1:0]  CNT_SAT = CNT_W'(TMO_MAX);
  localparam logic [WIDE_W-1:0] LIM_LO  = WIDE_W'(TMO_MIN);
  localparam logic [WIDE_W-1:0] LIM_HI  = WIDE_W'(TMO_MAX);

  // Input synchronizers, one flop chain per line
  logic [SYNC_STAGES-1:0] sckSync;
  logic [SYNC_STAGES-1:0] sdiSync;
  logic                   sckPrev;
  logic                   sckRise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sckSync <= '0;
      sdiSync <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      sdiSync <= {sdiSync[SYNC_STAGES-2:0], sdiIn};
      sckPrev <= sckSync[SYNC_STAGES-1];
    end
  end

  assign sckRise = sckSync[SYNC_STAGES-1] & ~sckPrev;

  // Edge spacing measurement and idle timer
  logic [CNT_W-1:0]  idleCnt;
  logic [CNT_W-1:0]  periodReg;
  logic              seenEdge;
  logic              armed;
  logic [WIDE_W-1:0] scaledLim;
  logic [CNT_W-1:0]  idleLim;
  logic              fire;
  logic              fwdPipe;

  always_comb begin
    scaledLim = WIDE_W'(periodReg) << TMO_SHIFT;
    if (scaledLim < LIM_LO)      idleLim = CNT_W'(TMO_MIN);
    else if (scaledLim > LIM_HI) idleLim = CNT_W'(TMO_MAX);
    else                         idleLim = scaledLim[CNT_W-1:0];
  end

  assign fire = armed && !sckRise && (idleCnt == idleLim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idleCnt    <= '0;
      periodReg  <= '0;
      seenEdge   <= 1'b0;
      armed      <= 1'b0;
      latchPulse <= 1'b0;
      fwdPipe    <= 1'b0;
      sckOut     <= 1'b0;
    end else begin
      fwdPipe    <= sckRise;
      sckOut     <= fwdPipe;
      latchPulse <= fire;
      if (sckRise) begin
        idleCnt  <= '0;
        armed    <= 1'b1;
        seenEdge <= 1'b1;
        if (seenEdge)
          periodReg <= (idleCnt == CNT_SAT) ? CNT_SAT : idleCnt + CNT_W'(1);
      end else begin
        if (idleCnt != CNT_SAT) idleCnt <= idleCnt + CNT_W'(1);
        if (fire) armed <= 1'b0;
      end
    end
  end

  assign strobe.shiftEn = sckRise;
  assign strobe.dataBit = sdiSync[SYNC_STAGES-1];
  assign strobe.latchEn = fire;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    latchPulse |=> !latchPulse); // R6
  AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sckOut |=> !sckOut); // R3
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    latchPulse |-> (!sckOut && !fwdPipe)); // R5

endmodule

// File: rtl/chain_datapath.sv
module chain_datapath
  import chain_pkg::*;
#(
  parameter int          WORD_W   = 224,
  parameter int          CMD_W    = 6,
  parameter logic [5:0]  CMD_CODE = 6'b100101
) (
  input  logic              clk,
  input  logic              rst,
  input  chainStrobe_t      strobe,
  output logic              sdoOut,
  output logic [WORD_W-1:0] holdWord
);

  localparam int TOP = WORD_W - 1;

  logic [WORD_W-1:0] shiftReg;
  logic              cmdOk;

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[TOP-1:0], strobe.dataBit};
  end

  assign cmdOk  = (shiftReg[TOP -: CMD_W] == CMD_CODE[CMD_W-1:0]);
  assign sdoOut = shiftReg[TOP];

  always_ff @(posedge clk) begin
    if (rst) holdWord <= '0;
    else if (strobe.latchEn && cmdOk) holdWord <= shiftReg;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.latchEn |=> $stable(holdWord)); // R7
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (rst)
    (strobe.latchEn && !cmdOk) |=> $stable(holdWord)); // R7
  AST_SDO_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> $stable(sdoOut)); // R2

endmodule

// File: rtl/serial_chain_latch.sv
module serial_chain_latch
  import chain_pkg::*;
#(
  parameter int         WORD_W      = 224,
  parameter int         CMD_W       = 6,
  parameter logic [5:0] CMD_CODE    = 6'b100101,
  parameter int         SYNC_STAGES = 2,
  parameter int         TMO_SHIFT   = 3,
  parameter int         TMO_MIN     = 8,
  parameter int         TMO_MAX     = 16384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sckIn,
  input  logic              sdiIn,
  output logic              sdoOut,
  output logic              sckOut,
  output logic              latchPulse,
  output logic [WORD_W-1:0] holdWord
);

  chainStrobe_t strobe;

  chain_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .TMO_SHIFT  (TMO_SHIFT),
    .TMO_MIN    (TMO_MIN),
    .TMO_MAX    (TMO_MAX)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sckIn     (sckIn),
    .sdiIn     (sdiIn),
    .strobe    (strobe),
    .sckOut    (sckOut),
    .latchPulse(latchPulse)
  );

  chain_datapath #(
    .WORD_W  (WORD_W),
    .CMD_W   (CMD_W),
    .CMD_CODE(CMD_CODE)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .sdoOut  (sdoOut),
    .holdWord(holdWord)
  );

endmodule

// File: tb/serial_chain_latch_bench.sv
`timescale 1ns/1ps
module serial_chain_latch_bench;

  localparam logic [5:0] CMD = 6'b100101;

  logic         clk = 1'b0;
  logic         rst;
  logic         sckIn;
  logic         sdiIn;
  logic         sdoOut;
  logic         sckOut;
  logic         latchPulse;
  logic [223:0] holdWord;

  always #2.5 clk = ~clk;

  serial_chain_latch u_serial_chain_latch (
    .clk(clk), .rst(rst), .sckIn(sckIn), .sdiIn(sdiIn),
    .sdoOut(sdoOut), .sckOut(sckOut), .latchPulse(latchPulse),
    .holdWord(holdWord)
  );

  int vecs = 0;
  int errs = 0;
  int latchSeen = 0;
  int fwdSeen = 0;
  int edgesSent = 0;
  logic [223:0] modelSr = '0;
  logic [223:0] expHold = '0;

  always @(negedge clk) begin
    if (latchPulse === 1'b1) latchSeen++;
    if (sckOut === 1'b1) fwdSeen++;
  end

  task automatic checkVal(string req, logic [255:0] act, logic [255:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One serial bit: data set while the clock is low, then a high phase.
  task automatic shiftBit(logic b, int half);
    sdiIn = b;
    repeat (half) @(negedge clk);
    checkVal("R2 sdo is bit shifted 224 edges back", 256'(sdoOut), 256'(modelSr[223]));
    sckIn = 1'b1;
    edgesSent++;
    modelSr = {modelSr[222:0], b};
    repeat (half) @(negedge clk);
    sckIn = 1'b0;
  endtask

  function automatic logic [223:0] makeWord(bit valid);
    logic [223:0] w;
    for (int k = 0; k < 7; k++) w[k*32 +: 32] = $urandom;
    w[223:218] = valid ? CMD : (CMD ^ 6'h0C);
    return w;
  endfunction

  function automatic bit codeOk(logic [223:0] w);
    return w[223:218] == CMD;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int base;
    int unused;
    unused = $urandom(32'h1A2B3C);
    rst = 1'b1; sckIn = 1'b0; sdiIn = 1'b0;
    repeat (4) @(negedge clk);
    checkVal("R9 hold cleared", 256'(holdWord), 256'(0));
    checkVal("R9 sdo cleared", 256'(sdoOut), 256'(0));
    checkVal("R9 sckOut low", 256'(sckOut), 256'(0));
    checkVal("R9 latch low", 256'(latchPulse), 256'(0));
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R8: lone edge after reset uses the 8-cycle minimum
    shiftBit(1'b1, 3);
    repeat (40) @(negedge clk);
    checkVal("R8 lone edge latches at minimum limit", 256'(latchSeen), 256'(1));
    checkVal("R7 bad code keeps hold", 256'(holdWord), 256'(expHold));

    for (int w = 0; w < 5; w++) begin
      int half;
      int gapAt;
      bit valid;
      logic [223:0] word;
      half  = 3 + int'($urandom % 4);
      gapAt = 40 + int'($urandom % 140);
      valid = (w != 2);
      word  = makeWord(valid);
      base  = latchSeen;
      for (int i = 223; i >= 0; i--) begin
        shiftBit(word[i], half);
        if (i == gapAt) repeat (6 * half) @(negedge clk);
      end
      checkVal("R5 short gap does not latch", 256'(latchSeen), 256'(base));
      repeat (20 * half + 60) @(negedge clk);
      checkVal("R4 R6 long gap latches once", 256'(latchSeen), 256'(base + 1));
      if (valid) begin
        expHold = word;
        checkVal("R1 hold equals shifted word", 256'(holdWord), 256'(word));
      end else begin
        checkVal("R7 bad code keeps hold", 256'(holdWord), 256'(expHold));
      end
    end

    checkVal("R3 one forwarded pulse per edge", 256'(fwdSeen), 256'(edgesSent));

    // R4 ceiling: period 4096 would give 32768, clamped to 16384
    base = latchSeen;
    shiftBit(1'b0, 2048);
    shiftBit(1'b1, 2048);
    repeat (10000) @(negedge clk);
    checkVal("R4 no latch before ceiling", 256'(latchSeen), 256'(base));
    repeat (10000) @(negedge clk);
    checkVal("R4 latch after clamped ceiling", 256'(latchSeen), 256'(base + 1));
    if (codeOk(modelSr)) expHold = modelSr;
    checkVal("R7 hold after slow word", 256'(holdWord), 256'(expHold));
    checkVal("R3 forwarded count after slow edges", 256'(fwdSeen), 256'(edgesSent));

    rst = 1'b1;
    repeat (2) @(negedge clk);
    checkVal("R9 reset clears hold", 256'(holdWord), 256'(0));
    checkVal("R9 reset clears sdo", 256'(sdoOut), 256'(0));
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule